// File: doc/BRIEF.md
# Bus Address Remapping Bridge

This bridge sits between a Wishbone master port and a Wishbone slave port that both use 32-bit data and 32-bit byte addresses. It rewrites the address of every access and passes everything else straight through. Write data, byte selects, cycle, strobe and write enable go from the master to the slave. Read data, acknowledge and error come back from the slave to the master. The bridge has no clock and no registers, so it adds no latency to any access.

The address goes through two optional stages, always in the same order. The window stage folds the address into a window defined by a base and a power-of-two span. The region stage then compares the folded address against a table of source regions. Each source region is aligned to its own power-of-two size. An address that falls inside a source region is moved to the same offset inside the paired destination region. All table entries are compared in parallel, and when several match, the entry with the lowest index wins. An address that matches no entry leaves the region stage unchanged.

Top module: `wb_addr_remap`

## Requirements
- R1: `s_dat_w`, `s_sel`, `s_we`, `s_stb` and `s_cyc` equal `m_dat_w`, `m_sel`, `m_we`, `m_stb` and `m_cyc` in the same cycle, with no register on the path.
- R2: `m_dat_r`, `m_ack` and `m_err` equal `s_dat_r`, `s_ack` and `s_err` in the same cycle.
- R3: With the window stage enabled, the folded address is `WIN_BASE + (m_adr mod 2^WIN_LOG2)`, taken modulo 2^32. For example, with base 0x0001_0000 and span 2^28, both 0x0000_0004 and 0x1000_0004 give 0x0001_0004.
- R4: A folded address inside source region i is sent to destination region i at the same offset. The offset is the low `REG_LOG2[i]` bits. For example, with 4 KiB regions and 0x0002_0000 paired with 0x2000_0000, the address 0x0002_0008 becomes 0x2000_0008.
- R5: An address inside a region whose source and destination bases are equal comes out unchanged.
- R6: When both stages are enabled, the region table is applied to the folded address and not to `m_adr`. For example, with base 0x1_0000, span 2^19, and the 64 KiB region at 0x0001_0000 paired with 0x1000_0000, input 0x0 becomes 0x1000_0000.
- R7: When the folded address hits no region, it is presented on `s_adr` as it is. For example, 0x0002_0000 becomes 0x0003_0000 in the configuration of R6. With the window stage disabled, a miss gives `s_adr == m_adr`.
- R8: When several source regions contain the address, the entry with the lowest index is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr | input | 32 | Master byte address |
| m_dat_w | input | 32 | Master write data |
| m_dat_r | output | 32 | Read data returned to the master |
| m_sel | input | 4 | Master byte selects |
| m_cyc | input | 1 | Master bus cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_ack | output | 1 | Acknowledge to the master |
| m_err | output | 1 | Error to the master |
| s_adr | output | 32 | Remapped byte address to the slave |
| s_dat_w | output | 32 | Write data to the slave |
| s_dat_r | input | 32 | Slave read data |
| s_sel | output | 4 | Byte selects to the slave |
| s_cyc | output | 1 | Bus cycle to the slave |
| s_stb | output | 1 | Strobe to the slave |
| s_we | output | 1 | Write enable to the slave |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |

## Verification
The bench builds three copies of the bridge, all fed from the same master and slave inputs.

- **Default build:** both stages are on, with base 0x1_0000, span 2^19, and one 64 KiB region moved to 0x1000_0000. This makes the fold-then-translate order and the fold-then-miss case observable.
- **Window-only build:** base 0x1_0000 and span 2^28, which exercises aliasing of addresses far apart and wrap at the top of the address space.
- **Region-only build:** five 4 KiB regions, including an identity region and an entry 4 that duplicates entry 1 with a different destination. This brings the lowest-index rule, the last byte of a region and the first address past a region within reach.

// File: rtl/wb_addr_remap.sv
module wb_addr_remap #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter bit          WIN_EN    = 1'b1,
  parameter logic [31:0] WIN_BASE  = 32'h0001_0000,
  parameter int          WIN_LOG2  = 19,
  parameter bit          REG_EN    = 1'b1,
  parameter int          REG_N     = 1,
  parameter logic [REG_N*32-1:0] SRC_BASE = 32'h0001_0000,
  parameter logic [REG_N*32-1:0] DST_BASE = 32'h1000_0000,
  parameter logic [REG_N*8-1:0]  REG_LOG2 = 8'd16
) (
  input  logic [AW-1:0]   m_adr,
  input  logic [DW-1:0]   m_dat_w,
  output logic [DW-1:0]   m_dat_r,
  input  logic [DW/8-1:0] m_sel,
  input  logic            m_cyc,
  input  logic            m_stb,
  input  logic            m_we,
  output logic            m_ack,
  output logic            m_err,
  output logic [AW-1:0]   s_adr,
  output logic [DW-1:0]   s_dat_w,
  input  logic [DW-1:0]   s_dat_r,
  output logic [DW/8-1:0] s_sel,
  output logic            s_cyc,
  output logic            s_stb,
  output logic            s_we,
  input  logic            s_ack,
  input  logic            s_err
);

  localparam int IDX_W = (REG_N > 1) ? $clog2(REG_N) : 1;
  localparam logic [AW-1:0] WIN_MASK = (AW'(1) << WIN_LOG2) - AW'(1);
  localparam logic [AW-1:0] WIN_ORG  = AW'(WIN_BASE);

  assign s_dat_w = m_dat_w;
  assign s_sel   = m_sel;
  assign s_cyc   = m_cyc;
  assign s_stb   = m_stb;
  assign s_we    = m_we;
  assign m_dat_r = s_dat_r;
  assign m_ack   = s_ack;
  assign m_err   = s_err;

  logic [AW-1:0] folded;
  assign folded = WIN_EN ? (WIN_ORG + (m_adr & WIN_MASK)) : m_adr;

  logic [REG_N-1:0]   match;
  logic [AW-1:0]      xlat [REG_N];
  logic               hit;
  logic [IDX_W-1:0]   idx;

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    localparam int L = int'(REG_LOG2[i*8 +: 8]);
    localparam logic [AW-1:0] MSK = (AW'(1) << L) - AW'(1);
    localparam logic [AW-1:0] SRC = AW'(SRC_BASE[i*32 +: 32]) & ~MSK;
    localparam logic [AW-1:0] DST = AW'(DST_BASE[i*32 +: 32]) & ~MSK;

    assign match[i] = REG_EN && ((folded & ~MSK) == SRC);
    assign xlat[i]  = DST | (folded & MSK);

    always_comb begin
      if (hit && idx == IDX_W'(i)) begin
        assert_dst_region_R4: assert ((s_adr & ~MSK) == DST);
        assert_offset_kept_R4: assert ((s_adr & MSK) == (m_adr & MSK & (WIN_EN ? WIN_MASK : '1)) ||
                                       WIN_EN);
      end
      if (match[i]) begin
        assert_lowest_wins_R8: assert (hit && idx <= IDX_W'(i));
      end
    end
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    s_adr = folded;
    for (int i = REG_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        idx   = IDX_W'(i);
        s_adr = xlat[i];
      end
    end
  end

  always_comb begin
    if (WIN_EN && !hit) begin
      assert_in_window_R3: assert ((s_adr - WIN_ORG) <= WIN_MASK);
    end
    if (!WIN_EN && !hit) begin
      assert_miss_untouched_R7: assert (s_adr == m_adr);
    end
  end

endmodule

// File: tb/wb_addr_remap_tb.sv
module wb_addr_remap_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_adr, m_dat_w, s_dat_r;
  logic [3:0]  m_sel;
  logic        m_cyc, m_stb, m_we, s_ack, s_err;

  logic [31:0] m_dat_r, s_adr, s_dat_w;
  logic [3:0]  s_sel;
  logic        m_ack, m_err, s_cyc, s_stb, s_we;

  wb_addr_remap u_dut (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r), .m_sel(m_sel),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_ack(m_ack), .m_err(m_err),
    .s_adr(s_adr), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_sel(s_sel),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_ack(s_ack), .s_err(s_err));

  logic [31:0] w_adr, w_dr, w_dw;
  logic [3:0]  w_sel;
  logic        w_ack, w_err, w_cyc, w_stb, w_we;

  wb_addr_remap #(
    .WIN_EN(1'b1), .WIN_BASE(32'h0001_0000), .WIN_LOG2(28), .REG_EN(1'b0)
  ) u_win (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(w_dr), .m_sel(m_sel),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_ack(w_ack), .m_err(w_err),
    .s_adr(w_adr), .s_dat_w(w_dw), .s_dat_r(s_dat_r), .s_sel(w_sel),
    .s_cyc(w_cyc), .s_stb(w_stb), .s_we(w_we), .s_ack(s_ack), .s_err(s_err));

  logic [31:0] r_adr, r_dr, r_dw;
  logic [3:0]  r_sel;
  logic        r_ack, r_err, r_cyc, r_stb, r_we;

  wb_addr_remap #(
    .WIN_EN(1'b0), .REG_EN(1'b1), .REG_N(5),
    .SRC_BASE({32'h0001_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000, 32'h0000_0000}),
    .DST_BASE({32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000}),
    .REG_LOG2({8'd12, 8'd12, 8'd12, 8'd12, 8'd12})
  ) u_reg (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(r_dr), .m_sel(m_sel),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_ack(r_ack), .m_err(r_err),
    .s_adr(r_adr), .s_dat_w(r_dw), .s_dat_r(s_dat_r), .s_sel(r_sel),
    .s_cyc(r_cyc), .s_stb(r_stb), .s_we(r_we), .s_ack(s_ack), .s_err(s_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a);
    @(negedge clk);
    m_adr = a;
    #1;
  endtask

  task automatic t_idle;
    @(negedge clk);
    #1;
    check("R1 idle stb", 32'(s_stb), 32'h0);
    check("R1 idle cyc", 32'(s_cyc), 32'h0);
    check("R2 idle ack", 32'(m_ack), 32'h0);
  endtask

  task automatic t_pass;
    @(negedge clk);
    m_dat_w = 32'hA5C3_0F1E; m_sel = 4'b1010; m_we = 1'b1; m_stb = 1'b1; m_cyc = 1'b1;
    s_dat_r = 32'h1357_9BDF; s_ack = 1'b1; s_err = 1'b0;
    #1;
    check("R1 dat_w", s_dat_w, 32'hA5C3_0F1E);
    check("R1 sel", 32'(s_sel), 32'hA);
    check("R1 we/stb/cyc", {29'd0, s_we, s_stb, s_cyc}, 32'h7);
    check("R2 dat_r", m_dat_r, 32'h1357_9BDF);
    check("R2 ack/err", {30'd0, m_ack, m_err}, 32'h2);
    @(negedge clk);
    m_we = 1'b0; s_ack = 1'b0; s_err = 1'b1; m_sel = 4'b0101;
    #1;
    check("R1 we low", 32'(s_we), 32'h0);
    check("R1 sel change", 32'(s_sel), 32'h5);
    check("R2 ack/err swap", {30'd0, m_ack, m_err}, 32'h1);
  endtask

  task automatic t_window;
    put(32'h0000_0004); check("R3 low", w_adr, 32'h0001_0004);
    put(32'h1000_0004); check("R3 alias", w_adr, 32'h0001_0004);
    put(32'hFFFF_FFFC); check("R3 top", w_adr, 32'h1000_FFFC);
  endtask

  task automatic t_region;
    put(32'h0002_0008); check("R4 region2", r_adr, 32'h2000_0008);
    put(32'h0003_000C); check("R4 region3", r_adr, 32'h3000_000C);
    put(32'h0003_0FFF); check("R4 last byte", r_adr, 32'h3000_0FFF);
    put(32'h0000_0000); check("R5 identity base", r_adr, 32'h0000_0000);
    put(32'h0000_0FFC); check("R5 identity end", r_adr, 32'h0000_0FFC);
  endtask

  task automatic t_chain;
    put(32'h0000_0000); check("R6 fold then map", s_adr, 32'h1000_0000);
    put(32'h0008_0010); check("R6 alias then map", s_adr, 32'h1000_0010);
    put(32'h0002_0000); check("R7 fold miss", s_adr, 32'h0003_0000);
  endtask

  task automatic t_miss;
    put(32'h0000_1000); check("R7 past region", r_adr, 32'h0000_1000);
    put(32'h0004_0000); check("R7 unmapped", r_adr, 32'h0004_0000);
  endtask

  task automatic t_prio;
    put(32'h0001_0ABC); check("R8 lowest index", r_adr, 32'h1000_0ABC);
    put(32'h0001_0000); check("R8 region base", r_adr, 32'h1000_0000);
  endtask

  initial begin
    m_adr = '0; m_dat_w = '0; m_sel = '0; m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0;
    s_dat_r = '0; s_ack = 1'b0; s_err = 1'b0;
    repeat (2) @(negedge clk);
    t_idle;
    t_pass;
    t_window;
    t_region;
    t_chain;
    t_miss;
    t_prio;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule